// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs on the DMA side of a network controller. It walks a circular ring of transmit descriptors that host software keeps in memory, and it passes ownership back and forth with the host through one bit. Each descriptor takes 16 bytes. Word 0 holds the buffer address. Word 1 holds flags and the byte count. Word 2 is a status word that the engine writes back.

After a start command, a transmit demand makes the engine read the flags word of the current entry. If the controller owns that entry, the engine fetches the buffer address and hands address, length and packet flags to a frame sender. It then waits for the sender to report done, writes the error status and releases the entry. It pulses a transmit interrupt and polls the next entry. The walk ends at the first entry the controller does not own.

The ring size is a power of two given as a 4-bit log2 value. The index wraps modulo that size. Memory is reached through a word-wide request/acknowledge port.

Top module: `txring_walker`

## Requirements
- R1: After reset, `mem_req`, `snd_start` and `tx_int` are low, and no memory access happens until the engine has been started and given a demand.
- R2: `ring_base` is 16-byte aligned. Entry i occupies `ring_base + 16*i`, with word 0 (buffer address) at offset 0, word 1 (flags/count) at offset 4 and word 2 (status) at offset 8. The first access after a demand is a read of word 1 of the current entry.
- R3: If word 1 bit 31 (ownership) reads 0, the engine goes idle. It starts no frame and writes nothing to that entry.
- R4: For an owned entry, `snd_addr` equals word 0, `snd_sop` equals word 1 bit 25 and `snd_eop` equals word 1 bit 24. `snd_start` is a single-cycle pulse.
- R5: `snd_len` is the 16-bit two's-complement negation of word 1 bits 15:0. If `pad_en` is high, both packet flags are set and that length is below `MIN_LEN` (default 60), `snd_len` is `MIN_LEN` instead.
- R6: After `snd_done`, the engine writes word 2 and then word 1, and word 1 is the last write for that entry.
  - Word 2 maps `snd_stat` bits 0..4 (retry failure, carrier loss, late collision, underflow, buffer error) to word 2 bits 26, 27, 28, 30 and 31, with all other bits 0.
  - Word 1 has bit 31 cleared, bit 30 set to the OR of `snd_stat`, and bits 29:0 kept.
- R7: `tx_int` pulses for one cycle, on the cycle after the acknowledge of the word 1 release write.
- R8: After a release the index advances modulo 2^`ring_log2` (values above `IDX_W` act as `IDX_W`), and the next entry is polled before the engine goes idle.
- R9: A demand while stopped is ignored. A demand that arrives while the engine is busy is remembered and causes one more poll once the walk ends.
- R10: `stop` halts the engine: no further frame is started and demands cause no memory access. `start`, taken only while the engine is idle, reloads the index to entry 0.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Enable engine and reload index to 0 (taken when idle) |
| stop | input | 1 | Disable engine |
| demand | input | 1 | Transmit demand: poll the ring |
| pad_en | input | 1 | Enable short-frame padding |
| ring_base | input | AW | Byte address of entry 0 |
| ring_log2 | input | 4 | log2 of the entry count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| snd_start | output | 1 | Start frame pulse |
| snd_addr | output | 32 | Buffer address |
| snd_len | output | 16 | Frame length in bytes |
| snd_sop | output | 1 | Start-of-packet flag |
| snd_eop | output | 1 | End-of-packet flag |
| snd_done | input | 1 | Frame finished |
| snd_stat | input | 5 | Frame error bits, valid with `snd_done` |
| tx_int | output | 1 | Transmit interrupt pulse |

## Verification
The bench memory acknowledges one clock after it sees a request, so each word access takes two clocks. `snd_start` follows the word 0 acknowledge by one cycle, and `tx_int` appears one clock after the cycle in which the release write was accepted. Outputs are sampled on the falling edge. The memory model and the sender model log every access and start with its cycle, so per-entry results are compared against these logs once the engine has gone quiet rather than at fixed delays. The interrupt delay is the one timing that is checked exactly: the bench measures it against the logged cycle of the last write.

// File: rtl/txring_walker.sv
module txring_walker #(
  parameter int AW      = 32,
  parameter int IDX_W   = 9,
  parameter int MIN_LEN = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          demand,
  input  logic          pad_en,
  input  logic [AW-1:0] ring_base,
  input  logic [3:0]    ring_log2,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          snd_start,
  output logic [31:0]   snd_addr,
  output logic [15:0]   snd_len,
  output logic          snd_sop,
  output logic          snd_eop,
  input  logic          snd_done,
  input  logic [4:0]    snd_stat,
  output logic          tx_int
);

  localparam logic [3:0]       LG_MAX   = 4'(IDX_W);
  localparam logic [IDX_W-1:0] IDX_ONES = '1;
  localparam logic [15:0]      PAD_LEN  = 16'(MIN_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_FLAG, S_ADDR, S_KICK, S_WAIT, S_STAT, S_REL
  } walk_t;

  walk_t            state;
  logic             run, pend;
  logic [IDX_W-1:0] idx;
  logic [31:0]      flags;
  logic [4:0]       stat;

  logic [3:0]       lg;
  logic [IDX_W-1:0] mask, idx_m, idx_nx;
  logic [3:0]       off;
  logic [15:0]      nlen;
  logic             take, short_pad;

  assign lg     = (ring_log2 > LG_MAX) ? LG_MAX : ring_log2;
  assign mask   = ~(IDX_ONES << lg);
  assign idx_m  = idx & mask;
  assign idx_nx = (idx_m + IDX_W'(1)) & mask;
  assign take   = (state == S_IDLE) && run && pend;

  always_comb begin
    case (state)
      S_FLAG, S_REL: off = 4'h4;
      S_STAT:        off = 4'h8;
      default:       off = 4'h0;
    endcase
  end

  assign mem_req   = (state == S_FLAG) || (state == S_ADDR) ||
                     (state == S_STAT) || (state == S_REL);
  assign mem_we    = (state == S_STAT) || (state == S_REL);
  assign mem_addr  = ring_base + AW'({idx_m, off});
  assign mem_wdata = (state == S_STAT)
                   ? {stat[4], stat[3], 1'b0, stat[2], stat[1], stat[0], 26'd0}
                   : {1'b0, |stat, flags[29:0]};

  assign nlen      = -flags[15:0];
  assign short_pad = pad_en && flags[25] && flags[24] && (nlen < PAD_LEN);
  assign snd_len   = short_pad ? PAD_LEN : nlen;
  assign snd_sop   = flags[25];
  assign snd_eop   = flags[24];
  assign snd_start = (state == S_KICK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      run      <= 1'b0;
      pend     <= 1'b0;
      idx      <= '0;
      flags    <= '0;
      stat     <= '0;
      snd_addr <= '0;
      tx_int   <= 1'b0;
    end else begin
      tx_int <= (state == S_REL) && mem_ack;
      if (stop)                             run <= 1'b0;
      else if (start && state == S_IDLE)    run <= 1'b1;
      pend <= !stop && ((demand && run) || (pend && !take));
      case (state)
        S_IDLE: begin
          if (start && !stop) idx <= '0;
          else if (take)      state <= S_FLAG;
        end
        S_FLAG: if (mem_ack) begin
          if (mem_rdata[31] && run) begin
            flags <= mem_rdata;
            state <= S_ADDR;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ADDR: if (mem_ack) begin
          snd_addr <= mem_rdata;
          state    <= S_KICK;
        end
        S_KICK: state <= S_WAIT;
        S_WAIT: if (snd_done) begin
          stat  <= snd_stat;
          state <= S_STAT;
        end
        S_STAT: if (mem_ack) state <= S_REL;
        S_REL: if (mem_ack) begin
          idx   <= idx_nx;
          state <= S_FLAG;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R6
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr[3:0] == 4'h4) |-> !mem_wdata[31]);

  // R7
  int_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |=> !tx_int);

  // R4
  kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_start |=> !snd_start);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !run) |=> !mem_req);

  // R3
  noown_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLAG && mem_ack && !mem_rdata[31]) |=> (!mem_req && !snd_start));

endmodule

// File: tb/txring_walker_tb.sv
module txring_walker_tb_top;
  localparam int BASE = 'h100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, stop, demand, pad_en;
  logic [31:0] ring_base;
  logic [3:0]  ring_log2;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        snd_start, snd_sop, snd_eop, snd_done, tx_int;
  logic [31:0] snd_addr;
  logic [15:0] snd_len;
  logic [4:0]  snd_stat;

  txring_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .demand(demand),
    .pad_en(pad_en), .ring_base(ring_base), .ring_log2(ring_log2),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snd_start(snd_start), .snd_addr(snd_addr), .snd_len(snd_len),
    .snd_sop(snd_sop), .snd_eop(snd_eop), .snd_done(snd_done),
    .snd_stat(snd_stat), .tx_int(tx_int)
  );

  logic [31:0] mem [0:255];
  int rlog [0:2047];
  int wlog [0:2047];
  int rn = 0, wn = 0, cyc = 0, wcyc = 0;
  logic        hw_en = 1'b0;
  logic [7:0]  hw_a = '0;
  logic [31:0] hw_d = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (hw_en) mem[hw_a] <= hw_d;
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          if (wn < 2048) wlog[wn] <= int'(mem_addr);
          wn   <= wn + 1;
          wcyc <= cyc;
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
          if (rn < 2048) rlog[rn] <= int'(mem_addr);
          rn <= rn + 1;
        end
      end
    end
  end

  logic [31:0] s_addr [0:511];
  int          s_len  [0:511];
  logic        s_sop  [0:511];
  logic        s_eop  [0:511];
  logic [4:0]  s_stat [0:511];
  int sn = 0;
  logic sbusy = 1'b0;

  initial begin
    snd_done = 1'b0;
    snd_stat = '0;
    forever begin
      @(negedge clk);
      if (snd_start) begin
        logic [4:0] st;
        int d;
        st = 5'($urandom_range(0, 31));
        if ($urandom % 2 == 0) st = '0;
        s_addr[sn] = snd_addr;
        s_len[sn]  = int'(snd_len);
        s_sop[sn]  = snd_sop;
        s_eop[sn]  = snd_eop;
        s_stat[sn] = st;
        sn = sn + 1;
        sbusy = 1'b1;
        d = 1 + int'($urandom % 5);
        repeat (d) @(negedge clk);
        snd_done = 1'b1;
        snd_stat = st;
        @(negedge clk);
        snd_done = 1'b0;
        sbusy = 1'b0;
      end
    end
  end

  int icnt = 0, lat_bad = 0;
  always @(negedge clk) begin
    if (rst_n && tx_int) begin
      icnt = icnt + 1;
      if ((cyc - wcyc) != 2 || (wlog[wn-1] & 15) != 4) lat_bad = lat_bad + 1;
    end
  end

  int total = 0, bad = 0;
  bit fin = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(int a, logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_a = 8'(a); hw_d = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  logic [31:0] o_w1  [0:7];
  logic [31:0] o_adr [0:7];
  int          o_len [0:7];
  int cur = 0;

  task automatic put_desc(int i, bit own, bit sop, bit eop, int len);
    logic [31:0] w1, ad;
    logic [3:0]  x4;
    logic [7:0]  x8;
    logic [15:0] nl;
    x4 = 4'($urandom);
    x8 = 8'($urandom);
    nl = 16'(-len);
    ad = $urandom;
    w1 = {own, 1'b0, x4, sop, eop, x8, nl};
    o_w1[i] = w1; o_adr[i] = ad; o_len[i] = len;
    hwr(64 + 4*i, ad);
    hwr(65 + 4*i, w1);
    hwr(66 + 4*i, 32'h1234_5678);
  endtask

  function automatic int exp_len(int len, bit sop, bit eop, bit pad);
    return (pad && sop && eop && len < 60) ? 60 : len;
  endfunction

  function automatic logic [31:0] exp_w2(logic [4:0] s);
    return {s[4], s[3], 1'b0, s[2], s[1], s[0], 26'd0};
  endfunction

  task automatic pulse_demand();
    @(negedge clk); demand = 1'b1;
    @(negedge clk); demand = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (mem_req || sbusy || snd_start) q = 0; else q = q + 1;
    end
  endtask

  task automatic go(int first, int count, int n, bit pad);
    int k0, w0, i0, r0;
    k0 = sn; w0 = wn; i0 = icnt; r0 = rn;
    pulse_demand();
    wait_idle();
    chk("R3/R8 frame count", sn - k0, count);
    chk("R7 interrupt count", icnt - i0, count);
    chk("R2 first poll address", rlog[r0], BASE + 16*first + 4);
    for (int m = 0; m < count; m++) begin
      int j, k;
      j = (first + m) % n;
      k = k0 + m;
      chk("R4 buffer address", s_addr[k], o_adr[j]);
      chk("R4 packet flags", {s_sop[k], s_eop[k]}, {o_w1[j][25], o_w1[j][24]});
      chk("R5 length", s_len[k], exp_len(o_len[j], o_w1[j][25], o_w1[j][24], pad));
      chk("R6 status word", mem[66 + 4*j], exp_w2(s_stat[k]));
      chk("R6 release word", mem[65 + 4*j], {1'b0, |s_stat[k], o_w1[j][29:0]});
      chk("R6 write order status", wlog[w0 + 2*m], BASE + 16*j + 8);
      chk("R6 write order release", wlog[w0 + 2*m + 1], BASE + 16*j + 4);
    end
    if (count < n) begin
      int j;
      j = (first + count) % n;
      chk("R3 unowned untouched", mem[65 + 4*j], o_w1[j]);
      chk("R8 stop entry polled", rlog[rn - 1], BASE + 16*j + 4);
    end
    cur = (first + count) % n;
  endtask

  initial begin
    int r0, k0, c;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; demand = 1'b0; pad_en = 1'b0;
    ring_base = BASE; ring_log2 = 4'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req after reset", mem_req, 0);
    chk("R1 snd_start after reset", snd_start, 0);
    chk("R1 tx_int after reset", tx_int, 0);

    for (int i = 0; i < 8; i++) put_desc(i, 0, 1, 1, 64);

    r0 = rn;
    pulse_demand();
    repeat (20) @(negedge clk);
    chk("R9 demand while stopped", rn - r0, 0);

    ring_log2 = 4'd2;
    pulse_start();
    for (int i = 0; i < 3; i++) put_desc(i, 1, 1'($urandom), 1'($urandom), 1 + int'($urandom % 1500));
    put_desc(3, 0, 1, 1, 80);
    go(0, 3, 4, 0);

    put_desc(3, 1, 1, 1, 200);
    put_desc(0, 1, 1, 0, 300);
    put_desc(1, 1, 0, 1, 40);
    put_desc(2, 0, 1, 1, 50);
    go(3, 3, 4, 0);

    pad_en = 1'b1;
    put_desc(2, 1, 1, 1, 20);
    put_desc(3, 1, 1, 1, 100);
    put_desc(0, 1, 1, 0, 20);
    put_desc(1, 0, 1, 1, 20);
    go(2, 3, 4, 1);
    chk("R5 short frame padded", s_len[sn - 3], 60);
    chk("R5 partial frame not padded", s_len[sn - 1], 20);
    pad_en = 1'b0;

    put_desc(1, 1, 1, 1, 500);
    put_desc(2, 0, 1, 1, 500);
    r0 = rn; k0 = sn;
    pulse_demand();
    while (!sbusy) @(negedge clk);
    pulse_demand();
    wait_idle();
    c = 0;
    for (int r = r0; r < rn; r++) if (rlog[r] == BASE + 16*2 + 4) c++;
    chk("R9 busy demand gives extra poll", c, 2);
    chk("R9 one frame sent", sn - k0, 1);
    cur = 2;

    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    put_desc(2, 1, 1, 1, 70);
    r0 = rn; k0 = sn;
    pulse_demand();
    repeat (30) @(negedge clk);
    chk("R10 no access when stopped", rn - r0, 0);
    chk("R10 no frame when stopped", sn - k0, 0);
    put_desc(2, 0, 1, 1, 70);
    put_desc(0, 1, 1, 1, 90);
    put_desc(1, 0, 1, 1, 90);
    pulse_start();
    go(0, 1, 4, 0);

    ring_log2 = 4'd0;
    put_desc(0, 1, 1, 1, 128);
    go(0, 1, 1, 0);

    ring_log2 = 4'd3;
    cur = 0;
    for (int rnd = 0; rnd < 15; rnd++) begin
      int cnt, f;
      pad_en = 1'($urandom);
      cnt = 1 + int'($urandom % 8);
      f = cur;
      for (int m = 0; m < cnt; m++)
        put_desc((f + m) % 8, 1, 1'($urandom), 1'($urandom), 1 + int'($urandom % 120));
      if (cnt < 8) put_desc((f + cnt) % 8, 0, 1, 1, 64);
      go(f, cnt, 8, pad_en);
    end

    chk("R7 interrupt one cycle after release ack", lat_bad, 0);

    if (!fin) begin
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule